// File: doc/BRIEF.md
# Pixel Input Port Selector

This block sits at the very front of a flat-panel timing controller. Pixel data can arrive in two ways. It can come as one 24-bit RGB stream at the full dot rate. It can also come as two 24-bit streams, odd and even, at half that rate. A static strap input picks between the two. Whatever the input arrangement, the block always hands the downstream datapath an odd/even pixel pair, together with a strobe that marks each pair as valid.

In single-stream mode, consecutive pixels that arrive while data enable is high are gathered into pairs. Each line starts on an odd pixel. In dual-stream mode, both buses are registered and passed through.

Horizontal and vertical sync each have a separate active-low strap that inverts that sync before use. All control outputs are delayed so that they line up with the pixel pairs. Every pixel bus packs red in bits [23:16], green in [15:8] and blue in [7:0]. Each colour is 8 bits wide by default.

Top module: `pix_port_sel`

## Requirements
- R1: While `rst_n` is low, every output (both pixel pair buses, `pair_vld`, `hs_out`, `vs_out`, `de_out`) is 0.
- R2: With `dual_mode` high, `odd_px_out`/`even_px_out` equal `odd_px_in`/`even_px_in` as sampled two rising edges earlier, and `pair_vld` equals `de_in` sampled two edges earlier.
- R3: With `dual_mode` low, the first pixel on `odd_px_in` sampled with `de_in` high becomes `odd_px_out` and the next one becomes `even_px_out`. `pair_vld` is high for exactly one cycle, starting on the second rising edge after the second pixel was sampled.
- R4: With `dual_mode` low, `even_px_in` has no effect on any output.
- R5: The pairing phase restarts whenever `de_in` is low. A pixel left without a partner when `de_in` falls is discarded and produces no strobe, and the next line pairs from its first pixel.
- R6: With `dual_mode` low, both pixel outputs hold their values in every cycle where `pair_vld` is low.
- R7: `hs_out` is `hs_in` delayed two edges, inverted when `hs_inv_n` is 0 and unchanged when it is 1.
- R8: `vs_out` is `vs_in` delayed two edges, inverted when `vs_inv_n` is 0 and unchanged when it is 1.
- R9: `de_out` is `de_in` delayed two edges, in both modes.
- R10: `pair_vld` is never high while `de_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dual_mode | input | 1 | 1: two half-rate buses; 0: one full-rate bus on the odd input |
| hs_inv_n | input | 1 | 0 inverts horizontal sync |
| vs_inv_n | input | 1 | 0 inverts vertical sync |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| de_in | input | 1 | Data enable |
| odd_px_in | input | 3*CW | Odd pixel, or the only pixel in single mode |
| even_px_in | input | 3*CW | Even pixel, unused in single mode |
| odd_px_out | output | 3*CW | Odd pixel of the pair |
| even_px_out | output | 3*CW | Even pixel of the pair |
| pair_vld | output | 1 | Pixel pair valid strobe |
| hs_out | output | 1 | Corrected, aligned horizontal sync |
| vs_out | output | 1 | Corrected, aligned vertical sync |
| de_out | output | 1 | Aligned data enable |

## Verification
A pairing phase stuck at the wrong value shows up on the first line after it goes wrong. Pixels swap between the odd and even outputs, or the strobe lands on the first pixel of a pair instead of the second, two edges after the affected pixel. A phase that fails to clear at the end of a line skews every pair in the following line, so the bench runs a line with an odd pixel count followed by a short line. A wrong polarity or delay stage shows on `hs_out`, `vs_out` or `de_out` two edges after the input toggles. Compared against `pair_vld`, the same fault also exposes a misaligned strobe.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // Registered control bits carried through the first stage
  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic dual;
  } ctl_t;

  // Apply a strap-selected inversion: inv_n low flips the signal
  function automatic logic pol_apply(input logic s, input logic inv_n);
    return inv_n ? s : ~s;
  endfunction

  // Pairing phase: 0 waits for an odd pixel, 1 waits for its even partner
  function automatic logic phase_next(input logic ph, input logic de, input logic dual);
    return (dual || !de) ? 1'b0 : ~ph;
  endfunction

endpackage

// File: rtl/pps_in_stage.sv
module pps_in_stage
  import pps_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dual_mode,
  input  logic            hs_inv_n,
  input  logic            vs_inv_n,
  input  logic            hs_in,
  input  logic            vs_in,
  input  logic            de_in,
  input  logic [3*CW-1:0] odd_in,
  input  logic [3*CW-1:0] even_in,
  output ctl_t            ctl_q,
  output logic [3*CW-1:0] odd_q,
  output logic [3*CW-1:0] even_q
);

  ctl_t ctl_d;

  always_comb begin
    ctl_d.hs   = pol_apply(hs_in, hs_inv_n);
    ctl_d.vs   = pol_apply(vs_in, vs_inv_n);
    ctl_d.de   = de_in;
    ctl_d.dual = dual_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      odd_q  <= '0;
      even_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      odd_q  <= odd_in;
      even_q <= even_in;
    end
  end

endmodule

// File: rtl/pps_pair.sv
module pps_pair
  import pps_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_t            ctl_q,
  input  logic [3*CW-1:0] odd_q,
  output logic [3*CW-1:0] held_odd,
  output logic            pair_fire,
  output logic            phase
);

  logic take_odd;

  assign take_odd  = !ctl_q.dual && ctl_q.de && !phase;
  assign pair_fire = !ctl_q.dual && ctl_q.de && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      held_odd <= '0;
    end else begin
      phase <= phase_next(phase, ctl_q.de, ctl_q.dual);
      if (take_odd) held_odd <= odd_q;
    end
  end

endmodule

// File: rtl/pps_out_stage.sv
module pps_out_stage
  import pps_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctl_t            ctl_q,
  input  logic [3*CW-1:0] odd_q,
  input  logic [3*CW-1:0] even_q,
  input  logic [3*CW-1:0] held_odd,
  input  logic            pair_fire,
  output logic [3*CW-1:0] odd_out,
  output logic [3*CW-1:0] even_out,
  output logic            pair_vld,
  output logic            hs_out,
  output logic            vs_out,
  output logic            de_out
);

  localparam int NCOL = 3;

  logic            load;
  logic [3*CW-1:0] nxt_odd;
  logic [3*CW-1:0] nxt_even;

  assign load     = ctl_q.dual | pair_fire;
  assign nxt_odd  = ctl_q.dual ? odd_q  : held_odd;
  assign nxt_even = ctl_q.dual ? even_q : odd_q;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        odd_out[c*CW +: CW]  <= '0;
        even_out[c*CW +: CW] <= '0;
      end else if (load) begin
        odd_out[c*CW +: CW]  <= nxt_odd[c*CW +: CW];
        even_out[c*CW +: CW] <= nxt_even[c*CW +: CW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_vld <= 1'b0;
      hs_out   <= 1'b0;
      vs_out   <= 1'b0;
      de_out   <= 1'b0;
    end else begin
      pair_vld <= ctl_q.dual ? ctl_q.de : pair_fire;
      hs_out   <= ctl_q.hs;
      vs_out   <= ctl_q.vs;
      de_out   <= ctl_q.de;
    end
  end

endmodule

// File: rtl/pix_port_sel.sv
module pix_port_sel
  import pps_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dual_mode,
  input  logic            hs_inv_n,
  input  logic            vs_inv_n,
  input  logic            hs_in,
  input  logic            vs_in,
  input  logic            de_in,
  input  logic [3*CW-1:0] odd_px_in,
  input  logic [3*CW-1:0] even_px_in,
  output logic [3*CW-1:0] odd_px_out,
  output logic [3*CW-1:0] even_px_out,
  output logic            pair_vld,
  output logic            hs_out,
  output logic            vs_out,
  output logic            de_out
);

  ctl_t            ctl_q;
  logic [3*CW-1:0] odd_q;
  logic [3*CW-1:0] even_q;
  logic [3*CW-1:0] held_odd;
  logic            pair_fire;
  logic            phase;

  // Named internal events for the checker
  logic dual_q;
  logic de_q;
  assign dual_q = ctl_q.dual;
  assign de_q   = ctl_q.de;

  pps_in_stage #(.CW(CW)) u_in (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .hs_inv_n(hs_inv_n), .vs_inv_n(vs_inv_n),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .odd_in(odd_px_in), .even_in(even_px_in),
    .ctl_q(ctl_q), .odd_q(odd_q), .even_q(even_q)
  );

  pps_pair #(.CW(CW)) u_pair (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q), .odd_q(odd_q),
    .held_odd(held_odd), .pair_fire(pair_fire), .phase(phase)
  );

  pps_out_stage #(.CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .ctl_q(ctl_q),
    .odd_q(odd_q), .even_q(even_q), .held_odd(held_odd), .pair_fire(pair_fire),
    .odd_out(odd_px_out), .even_out(even_px_out), .pair_vld(pair_vld),
    .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
  );

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int CW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hs_inv_n,
  input logic            vs_inv_n,
  input logic            hs_in,
  input logic            vs_in,
  input logic            de_in,
  input logic            dual_q,
  input logic            de_q,
  input logic            phase,
  input logic            pair_fire,
  input logic [3*CW-1:0] odd_q,
  input logic [3*CW-1:0] odd_px_out,
  input logic [3*CW-1:0] even_px_out,
  input logic            pair_vld,
  input logic            hs_out,
  input logic            vs_out,
  input logic            de_out
);

  // Edges since reset release, saturating at the pipeline depth
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_dual_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dual_q) |-> (pair_vld == de_out));

  p_fire_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> !pair_fire);

  p_pair_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pair_fire |=> (pair_vld && even_px_out == $past(odd_q)));

  p_phase_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !de_q |=> !phase);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && !$past(dual_q) && !pair_vld) |->
      ($stable(odd_px_out) && $stable(even_px_out)));

  p_hs_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (hs_out == ($past(hs_in, 2) ^ !$past(hs_inv_n, 2))));

  p_vs_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (vs_out == ($past(vs_in, 2) ^ !$past(vs_inv_n, 2))));

  p_de_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (de_out == $past(de_in, 2)));

  p_vld_in_de_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld |-> de_out);

endmodule

bind pix_port_sel pps_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_inv_n(hs_inv_n), .vs_inv_n(vs_inv_n),
  .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
  .dual_q(dual_q), .de_q(de_q), .phase(phase), .pair_fire(pair_fire),
  .odd_q(odd_q), .odd_px_out(odd_px_out), .even_px_out(even_px_out),
  .pair_vld(pair_vld), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
);

// File: tb/tb_pix_port_sel.sv
module tb_pix_port_sel;
  localparam int CLK_NS = 10;
  localparam int CW     = 8;
  localparam int PW     = 3 * CW;
  localparam int DEPTH  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_mode = 1'b1, hs_inv_n = 1'b1, vs_inv_n = 1'b1;
  logic hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [PW-1:0] odd_px_in = '0, even_px_in = '0;
  logic [PW-1:0] odd_px_out, even_px_out;
  logic pair_vld, hs_out, vs_out, de_out;

  always #(CLK_NS/2) clk = ~clk;

  pix_port_sel #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
    .hs_inv_n(hs_inv_n), .vs_inv_n(vs_inv_n),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .odd_px_in(odd_px_in), .even_px_in(even_px_in),
    .odd_px_out(odd_px_out), .even_px_out(even_px_out),
    .pair_vld(pair_vld), .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [PW-1:0] s_odd [DEPTH];
  logic [PW-1:0] s_even[DEPTH];
  logic          s_de  [DEPTH];
  logic          s_hs  [DEPTH];
  logic          s_vs  [DEPTH];
  logic [PW-1:0] c_odd [DEPTH];
  logic [PW-1:0] c_even[DEPTH];
  logic          c_vld [DEPTH];
  logic          c_hs  [DEPTH];
  logic          c_vs  [DEPTH];
  logic          c_de  [DEPTH];
  logic          e_vld [DEPTH];
  logic [PW-1:0] e_odd [DEPTH];
  logic [PW-1:0] e_even[DEPTH];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Drive stored stimulus one cycle at a time; capture outputs at the next falling edge
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      odd_px_in  = s_odd[i];
      even_px_in = s_even[i];
      de_in      = s_de[i];
      hs_in      = s_hs[i];
      vs_in      = s_vs[i];
      @(negedge clk);
      c_odd[i]  = odd_px_out;
      c_even[i] = even_px_out;
      c_vld[i]  = pair_vld;
      c_hs[i]   = hs_out;
      c_vs[i]   = vs_out;
      c_de[i]   = de_out;
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < DEPTH; i++) begin
      s_odd[i] = '0; s_even[i] = '0; s_de[i] = 1'b0; s_hs[i] = 1'b0; s_vs[i] = 1'b0;
    end
  endtask

  // Single-stream expectation from the pairing rules: the pair shows one capture after its second pixel
  task automatic expect_single(input int n);
    logic ph;
    logic [PW-1:0] first;
    ph = 1'b0;
    first = '0;
    for (int i = 0; i < DEPTH; i++) begin
      e_vld[i] = 1'b0; e_odd[i] = '0; e_even[i] = '0;
    end
    for (int i = 0; i < n - 1; i++) begin
      if (!s_de[i]) ph = 1'b0;
      else if (!ph) begin first = s_odd[i]; ph = 1'b1; end
      else begin
        e_vld[i+1] = 1'b1; e_odd[i+1] = first; e_even[i+1] = s_odd[i]; ph = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    dual_mode = 1'b1; de_in = 1'b1; hs_in = 1'b1; vs_in = 1'b1;
    odd_px_in = '1; even_px_in = '1;
    repeat (3) @(negedge clk);
    check("R1 odd_px_out in reset", 32'(odd_px_out), 32'h0);
    check("R1 even_px_out in reset", 32'(even_px_out), 32'h0);
    check("R1 pair_vld in reset", 32'(pair_vld), 32'h0);
    check("R1 syncs/de in reset", {29'd0, hs_out, vs_out, de_out}, 32'h0);
    de_in = 1'b0; hs_in = 1'b0; vs_in = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_dual();
    int n;
    n = 16;
    clear_stim();
    dual_mode = 1'b1;
    for (int i = 0; i < n; i++) begin
      s_de[i]   = (i >= 2 && i < 10);
      s_odd[i]  = {8'(i + 1), 8'(i + 64), 8'(i + 128)};
      s_even[i] = ~s_odd[i] ^ PW'(i << 4);
      s_hs[i]   = (i == 12);
    end
    run(n);
    for (int i = 0; i < n - 1; i++) begin
      check("R2 dual odd", 32'(c_odd[i+1]), 32'(s_odd[i]));
      check("R2 dual even", 32'(c_even[i+1]), 32'(s_even[i]));
      check("R2 dual strobe", 32'(c_vld[i+1]), 32'(s_de[i]));
      check("R9 dual de delay", 32'(c_de[i+1]), 32'(s_de[i]));
    end
  endtask

  task automatic t_single();
    int n;
    n = 16;
    clear_stim();
    dual_mode = 1'b0;
    for (int i = 0; i < n; i++) begin
      s_de[i]   = (i >= 2 && i < 10);
      s_odd[i]  = {8'(3 * i + 7), 8'(i ^ 8'h5A), 8'(200 - i)};
      s_even[i] = {3{8'hA5}} ^ PW'(i * 24'h010203);
    end
    expect_single(n);
    run(n);
    for (int i = 1; i < n; i++) begin
      check("R3 single strobe", 32'(c_vld[i]), 32'(e_vld[i]));
      if (e_vld[i]) begin
        check("R3 single odd of pair", 32'(c_odd[i]), 32'(e_odd[i]));
        check("R4 single even from odd bus", 32'(c_even[i]), 32'(e_even[i]));
      end
      if (i >= 2 && !c_vld[i]) begin
        check("R6 odd hold", 32'(c_odd[i]), 32'(c_odd[i-1]));
        check("R6 even hold", 32'(c_even[i]), 32'(c_even[i-1]));
      end
      if (c_vld[i]) check("R10 strobe within de", 32'(c_de[i]), 32'h1);
      check("R9 single de delay", 32'(c_de[i]), 32'(s_de[i-1]));
    end
  endtask

  task automatic t_restart();
    int n;
    int strobes;
    n = 14;
    strobes = 0;
    clear_stim();
    dual_mode = 1'b0;
    for (int i = 0; i < n; i++) begin
      s_de[i]   = (i >= 2 && i <= 4) || (i >= 7 && i <= 8);
      s_odd[i]  = {8'(i + 16), 8'(i + 32), 8'(i + 48)};
      s_even[i] = '1;
    end
    run(n);
    for (int i = 1; i < n; i++) if (c_vld[i]) strobes++;
    check("R5 strobe count, unpaired pixel dropped", 32'(strobes), 32'd2);
    check("R5 first pair strobe", 32'(c_vld[4]), 32'h1);
    check("R5 no strobe for lone pixel", 32'(c_vld[5]), 32'h0);
    check("R5 new line starts odd", 32'(c_odd[9]), 32'(s_odd[7]));
    check("R5 new line even", 32'(c_even[9]), 32'(s_odd[8]));
    check("R5 pair strobe next line", 32'(c_vld[9]), 32'h1);
  endtask

  task automatic t_pol(input logic hinv_n, input logic vinv_n);
    int n;
    n = 12;
    clear_stim();
    dual_mode = 1'b1;
    hs_inv_n = hinv_n;
    vs_inv_n = vinv_n;
    for (int i = 0; i < n; i++) begin
      s_hs[i] = (i % 3 == 0);
      s_vs[i] = (i % 4 < 2);
      s_de[i] = i[0];
    end
    run(n);
    for (int i = 0; i < n - 1; i++) begin
      check("R7 hsync polarity", 32'(c_hs[i+1]), 32'(hinv_n ? s_hs[i] : !s_hs[i]));
      check("R8 vsync polarity", 32'(c_vs[i+1]), 32'(vinv_n ? s_vs[i] : !s_vs[i]));
      check("R9 de alignment", 32'(c_de[i+1]), 32'(s_de[i]));
    end
    hs_inv_n = 1'b1;
    vs_inv_n = 1'b1;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_dual();
    t_single();
    t_restart();
    t_pol(1'b0, 1'b1);
    t_pol(1'b1, 1'b0);
    t_dual();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule